// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block lets clocked logic read and write an external asynchronous static RAM of 16-bit words with separate upper and lower byte strobes. A client offers one request at a time on a valid/ready handshake: a word address, a write flag, write data and a two-bit lane mask. The controller then drives the RAM pins for the whole access. These pins are the address, an active-low and an active-high chip select, write and output enables, two byte strobes and a shared tri-state data bus. Reads come back as a single-cycle response pulse.

The RAM's timing limits are given in nanoseconds. They are turned into clock counts at elaboration from a clock-period parameter. Each count is rounded up and is never less than one cycle. A write keeps the write strobe low long enough to meet the pulse width, the byte-strobe width and the data setup together. The bus stays driven for one further cycle after the strobe rises, which gives the hold time. A read holds output enable low for the longer of the cycle time and the address access time. The bus is sampled on the last cycle of that window.

Top module: `sram_async_ctl`

## Requirements
- R1: While reset is applied and after it is released, the RAM is deselected (`sram_ce1_n`=1, `sram_ce2`=0), `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are 1, `req_ready` is 1 and `rsp_valid` is 0.
- R2: The two chip selects are always opposite. The RAM is selected (`sram_ce1_n`=0, `sram_ce2`=1) exactly while an access is in progress.
- R3: While selected, `sram_addr` equals the accepted `req_addr` and does not change. The strobes follow the mask: `sram_lb_n` = !`req_mask[0]` (data bits 7:0) and `sram_ub_n` = !`req_mask[1]` (bits 15:8).
- R4: A write holds `sram_we_n` low for exactly ceil(max(write pulse, strobe width, data setup)/clock) cycles, which is 5 at 8 ns. `sram_oe_n` stays 1 whenever `sram_we_n` is 0.
- R5: After `sram_we_n` rises, the chip stays selected and the write data stays on the bus for one more cycle. Only lanes whose mask bit is 1 change in the RAM. A mask of 00 changes nothing.
- R6: A read holds `sram_oe_n` low with `sram_we_n` high for exactly ceil(max(cycle, access)/clock) cycles, which is 6 at 8 ns. `rsp_valid` is a one-cycle pulse in the cycle right after that window.
- R7: `rsp_rdata` returns the RAM word with every lane whose mask bit is 0 forced to zero.
- R8: `req_ready` is 1 only when no access is in progress. A write occupies pulse+1 cycles and a read occupies its window. In both cases the request after an accept is taken one cycle after the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle, request taken on valid and ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 = bits 7:0, bit 1 = bits 15:8 |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, masked lanes zero |
| sram_addr | output | 19 | RAM address |
| sram_ce1_n | output | 1 | Active-low chip select |
| sram_ce2 | output | 1 | Active-high chip select |
| sram_we_n | output | 1 | Write strobe |
| sram_oe_n | output | 1 | Output enable |
| sram_ub_n | output | 1 | Upper byte strobe |
| sram_lb_n | output | 1 | Lower byte strobe |
| sram_dq | inout | 16 | Tri-state data bus |

## Verification
The bench builds the block with its defaults: 19 address bits, 16 data bits, an 8 ns clock and 45/35/35/25 ns limits. These give 5-cycle write pulses and 6-cycle reads, so every strobe width can be counted exactly against a number the bench derives itself. A bench RAM model decodes only the low six address bits. This makes all 64 of its words reachable in a full sweep while distinct upper address bits are still checked on the pins. Every lane-mask value is exercised for both writes and reads over that sweep, which covers the partial writes, the empty mask and the zeroing of masked read lanes.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_WPULSE = 2'd1,
      PH_WHOLD  = 2'd2,
      PH_READ   = 2'd3
   } phase_e;

   function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                input int unsigned clk_ns);
      int unsigned c;
      c = (t_ns + clk_ns - 1) / clk_ns;
      if (c == 0) c = 1;
      return c;
   endfunction

   function automatic int unsigned max2(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
   import sram_ctl_pkg::*;
#(
   parameter int unsigned RD_CYC = 6,
   parameter int unsigned WR_CYC = 5,
   parameter int unsigned CNT_W  = 3
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   req_valid,
   input  logic   req_write,
   output logic   req_ready,
   output logic   accept,
   output phase_e phase_d,
   output logic   capture
);

   localparam logic [CNT_W-1:0] RD_LOAD = CNT_W'(RD_CYC - 1);
   localparam logic [CNT_W-1:0] WR_LOAD = CNT_W'(WR_CYC - 1);

   phase_e           phase_q;
   logic [CNT_W-1:0] cnt_q, cnt_d;

   assign req_ready = (phase_q == PH_IDLE);
   assign accept    = req_valid && req_ready;

   always_comb begin
      phase_d = phase_q;
      cnt_d   = cnt_q;
      capture = 1'b0;
      case (phase_q)
         PH_IDLE: begin
            if (req_valid) begin
               phase_d = req_write ? PH_WPULSE : PH_READ;
               cnt_d   = req_write ? WR_LOAD : RD_LOAD;
            end
         end
         PH_WPULSE: begin
            if (cnt_q == '0) phase_d = PH_WHOLD;
            else             cnt_d   = cnt_q - 1'b1;
         end
         PH_WHOLD: phase_d = PH_IDLE;
         PH_READ: begin
            if (cnt_q == '0) begin
               phase_d = PH_IDLE;
               capture = 1'b1;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
         default: phase_d = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else begin
         phase_q <= phase_d;
         cnt_q   <= cnt_d;
      end
   end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W = 19,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  phase_e            phase_d,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [LANES-1:0]  req_mask,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] wdata_q,
   output logic [LANES-1:0]  be_n_q,
   output logic              ce1_n_q,
   output logic              ce2_q,
   output logic              we_n_q,
   output logic              oe_n_q,
   output logic              drive_q
);

   logic selected_d;
   assign selected_d = (phase_d != PH_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
         be_n_q  <= '1;
         ce1_n_q <= 1'b1;
         ce2_q   <= 1'b0;
         we_n_q  <= 1'b1;
         oe_n_q  <= 1'b1;
         drive_q <= 1'b0;
      end else begin
         if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_n_q  <= ~req_mask;
         end else if (!selected_d) begin
            be_n_q  <= '1;
         end
         ce1_n_q <= !selected_d;
         ce2_q   <= selected_d;
         we_n_q  <= (phase_d != PH_WPULSE);
         oe_n_q  <= (phase_d != PH_READ);
         drive_q <= (phase_d == PH_WPULSE) || (phase_d == PH_WHOLD);
      end
   end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
   parameter int unsigned DATA_W = 16,
   parameter int unsigned LANES  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [LANES-1:0]  be_n,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] rdata_q,
   output logic              rvalid_q
);

   localparam int unsigned LANE_W = DATA_W / LANES;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rvalid_q <= 1'b0;
      else        rvalid_q <= capture;
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rdata_q[g*LANE_W +: LANE_W] <= '0;
         end else if (capture) begin
            rdata_q[g*LANE_W +: LANE_W] <= be_n[g] ? '0 : bus_in[g*LANE_W +: LANE_W];
         end
      end
   end

endmodule

// File: rtl/sram_async_ctl.sv
module sram_async_ctl
   import sram_ctl_pkg::*;
#(
   parameter int unsigned ADDR_W    = 19,
   parameter int unsigned DATA_W    = 16,
   parameter int unsigned CLK_NS    = 8,
   parameter int unsigned T_CYC_NS  = 45,
   parameter int unsigned T_ACC_NS  = 45,
   parameter int unsigned T_WPW_NS  = 35,
   parameter int unsigned T_BEW_NS  = 35,
   parameter int unsigned T_DSU_NS  = 25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_mask,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [ADDR_W-1:0] sram_addr,
   output logic              sram_ce1_n,
   output logic              sram_ce2,
   output logic              sram_we_n,
   output logic              sram_oe_n,
   output logic              sram_ub_n,
   output logic              sram_lb_n,
   inout  wire  [DATA_W-1:0] sram_dq
);

   localparam int unsigned LANES  = DATA_W / 8;
   localparam int unsigned RD_CYC = ns_to_cycles(max2(T_CYC_NS, T_ACC_NS), CLK_NS);
   localparam int unsigned WR_CYC = ns_to_cycles(max2(max2(T_WPW_NS, T_BEW_NS), T_DSU_NS), CLK_NS);
   localparam int unsigned CNT_W  = $clog2(max2(RD_CYC, WR_CYC) + 1);

   if (CLK_NS == 0)        $error("clock period must be nonzero");
   if (DATA_W % 8 != 0)    $error("data width must be whole bytes");
   if (LANES != 2)         $error("two byte strobes need exactly two lanes");
   if (ADDR_W == 0)        $error("address width must be nonzero");

   logic              accept, capture, drive;
   phase_e            phase_d;
   logic [LANES-1:0]  be_n;
   logic [DATA_W-1:0] wdata;

   sram_ctl_seq #(.RD_CYC(RD_CYC), .WR_CYC(WR_CYC), .CNT_W(CNT_W)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_ready (req_ready),
      .accept    (accept),
      .phase_d   (phase_d),
      .capture   (capture)
   );

   sram_ctl_pins #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LANES(LANES)) u_pins (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .phase_d   (phase_d),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .req_mask  (req_mask),
      .addr_q    (sram_addr),
      .wdata_q   (wdata),
      .be_n_q    (be_n),
      .ce1_n_q   (sram_ce1_n),
      .ce2_q     (sram_ce2),
      .we_n_q    (sram_we_n),
      .oe_n_q    (sram_oe_n),
      .drive_q   (drive)
   );

   sram_ctl_rdcap #(.DATA_W(DATA_W), .LANES(LANES)) u_rdcap (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .be_n     (be_n),
      .bus_in   (sram_dq),
      .rdata_q  (rsp_rdata),
      .rvalid_q (rsp_valid)
   );

   assign sram_lb_n = be_n[0];
   assign sram_ub_n = be_n[LANES-1];
   assign sram_dq   = drive ? wdata : 'z;

endmodule

// File: rtl/sram_async_ctl_chk.sv
module sram_async_ctl_chk #(
   parameter int unsigned ADDR_W = 19
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] sram_addr,
   input logic              sram_ce1_n,
   input logic              sram_ce2,
   input logic              sram_we_n,
   input logic              sram_oe_n,
   input logic              sram_ub_n,
   input logic              sram_lb_n
);

   assert_select_opposite_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sram_ce1_n == !sram_ce2);

   assert_addr_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!sram_ce1_n && $past(!sram_ce1_n)) |->
         ($stable(sram_addr) && $stable({sram_ub_n, sram_lb_n})));

   assert_oe_off_in_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !sram_we_n |-> sram_oe_n);

   assert_hold_after_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sram_we_n) |-> !sram_ce1_n);

   assert_rsp_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   assert_rsp_after_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(!sram_oe_n));

   assert_ready_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (sram_ce1_n && sram_we_n && sram_oe_n));

endmodule

bind sram_async_ctl sram_async_ctl_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .rsp_valid  (rsp_valid),
   .sram_addr  (sram_addr),
   .sram_ce1_n (sram_ce1_n),
   .sram_ce2   (sram_ce2),
   .sram_we_n  (sram_we_n),
   .sram_oe_n  (sram_oe_n),
   .sram_ub_n  (sram_ub_n),
   .sram_lb_n  (sram_lb_n)
);

// File: tb/sram_async_ctl_test.sv
module sram_async_ctl_test;

   localparam int WR_EXP = (35 + 7) / 8;
   localparam int RD_EXP = (45 + 7) / 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_write = 1'b0;
   logic [18:0] req_addr = '0;
   logic [15:0] req_wdata = '0;
   logic [1:0]  req_mask = '0;
   logic        req_ready, rsp_valid;
   logic [15:0] rsp_rdata;
   logic [18:0] sram_addr;
   logic        sram_ce1_n, sram_ce2, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
   wire  [15:0] sram_dq;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [15:0] mem [64];
   logic [15:0] expv [64];
   logic [18:0] cur_addr = '0;
   logic [1:0]  cur_mask = '0;
   int          we_low = 0;
   int          oe_low = 0;
   logic        we_prev = 1'b1;
   logic        oe_prev = 1'b1;

   always #4 clk = ~clk;

   sram_async_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .sram_addr(sram_addr), .sram_ce1_n(sram_ce1_n), .sram_ce2(sram_ce2),
      .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
      .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n), .sram_dq(sram_dq)
   );

   // RAM model: 64 words decoded from the low six address bits
   logic sel, rd_en;
   assign sel   = !sram_ce1_n && sram_ce2;
   assign rd_en = sel && !sram_oe_n && sram_we_n;
   assign sram_dq[7:0]  = (rd_en && !sram_lb_n) ? mem[sram_addr[5:0]][7:0]  : 8'bz;
   assign sram_dq[15:8] = (rd_en && !sram_ub_n) ? mem[sram_addr[5:0]][15:8] : 8'bz;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         if (sel && !sram_we_n) begin
            if (!sram_lb_n) mem[sram_addr[5:0]][7:0]  <= sram_dq[7:0];
            if (!sram_ub_n) mem[sram_addr[5:0]][15:8] <= sram_dq[15:8];
         end
         chk(sram_ce1_n == !sram_ce2, "R2 select polarity", sram_ce1_n, !sram_ce2);
         if (sel) begin
            chk(sram_addr == cur_addr, "R3 address", sram_addr, cur_addr);
            chk({sram_ub_n, sram_lb_n} == ~cur_mask, "R3 strobes",
                {sram_ub_n, sram_lb_n}, ~cur_mask);
         end
         if (!sram_we_n) begin
            we_low++;
            chk(sram_oe_n, "R4 oe high during write", sram_oe_n, 1);
         end else if (!we_prev) begin
            chk(we_low == WR_EXP, "R4 write pulse width", we_low, WR_EXP);
            chk(sel, "R5 select held after strobe", sel, 1);
            chk(sram_dq == req_wdata, "R5 data held after strobe", sram_dq, req_wdata);
            we_low = 0;
         end
         if (!sram_oe_n) begin
            oe_low++;
            chk(sram_we_n, "R6 we high during read", sram_we_n, 1);
         end else if (!oe_prev) begin
            chk(oe_low == RD_EXP, "R6 read window", oe_low, RD_EXP);
            oe_low = 0;
         end
         we_prev = sram_we_n;
         oe_prev = sram_oe_n;
      end
   end

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         finish_run();
      end
   end

   function automatic logic [15:0] lane_mask(input logic [1:0] m);
      return {{8{m[1]}}, {8{m[0]}}};
   endfunction

   function automatic logic [18:0] mk_addr(input int a);
      return {13'(a * 97 + 1000), 6'(a)};
   endfunction

   task automatic do_write(input int a, input logic [15:0] d, input logic [1:0] m);
      int n;
      @(negedge clk);
      chk(req_ready, "R8 ready before write", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b1; req_addr = mk_addr(a);
      req_wdata = d; req_mask = m;
      cur_addr = mk_addr(a); cur_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!req_ready && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(n == WR_EXP + 2, "R8 write occupancy", n, WR_EXP + 2);
      expv[a] = (expv[a] & ~lane_mask(m)) | (d & lane_mask(m));
   endtask

   task automatic do_read(input int a, input logic [1:0] m);
      int n;
      logic [15:0] e;
      @(negedge clk);
      chk(req_ready, "R8 ready before read", req_ready, 1);
      req_valid = 1'b1; req_write = 1'b0; req_addr = mk_addr(a);
      req_mask = m;
      cur_addr = mk_addr(a); cur_mask = m;
      @(negedge clk);
      req_valid = 1'b0;
      n = 1;
      while (!rsp_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      chk(n == RD_EXP + 1, "R6 response latency", n, RD_EXP + 1);
      e = expv[a] & lane_mask(m);
      chk(rsp_rdata == e, "R7 read data and lane zeroing", rsp_rdata, e);
      chk(req_ready, "R8 ready with response", req_ready, 1);
      @(negedge clk);
      chk(!rsp_valid, "R6 response single pulse", rsp_valid, 0);
   endtask

   initial begin
      for (int i = 0; i < 64; i++) begin
         mem[i]  = '0;
         expv[i] = '0;
      end
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(sram_ce1_n && !sram_ce2, "R1 deselected in reset", {sram_ce1_n, sram_ce2}, 2'b10);
      chk(sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n, "R1 strobes idle in reset",
          {sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n}, 4'hf);
      chk(!rsp_valid, "R1 no response in reset", rsp_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready, "R1 ready after reset", req_ready, 1);
      chk(sram_ce1_n && !sram_ce2, "R1 deselected after reset", {sram_ce1_n, sram_ce2}, 2'b10);

      for (int a = 0; a < 64; a++)
         do_write(a, 16'(a * 16'h0101) ^ 16'hA55A, 2'b11);
      for (int a = 0; a < 64; a++)
         do_write(a, 16'(a * 16'h3C1F) ^ 16'h5AA5, 2'(a % 4));   // R5 partial and empty masks
      for (int a = 0; a < 64; a++) begin
         do_read(a, 2'b11);
         do_read(a, 2'((a + 1) % 4));                             // R7 masked lanes
      end
      // back-to-back write then read of the same word
      do_write(7, 16'hBEEF, 2'b11);
      do_read(7, 2'b11);
      do_write(7, 16'h1234, 2'b00);
      do_read(7, 2'b11);

      finish_run();
   end

endmodule